// File: doc/BRIEF.md
# Chip-Select Cycle Termination Controller

This block sits behind the address decoder of an external memory bus. Once an access has been matched to one of the chip-select regions, the block decides how that bus cycle ends. It then drives the one-hot chip-select lines and the address/attribute valid strobe. Each region carries its own option set, loaded through a small configuration write port:

- a 5-bit wait code;
- a read address-hold enable;
- a protect enable with a direction bit;
- a 2-bit memory-kind code.

Wait codes 0 to 30 end the access with an internal acknowledge after that many clocks. Code 31 hands termination to something outside the block. For a region of memory kind 01 (SDRAM) that is the SDRAM controller, reached through a start/done handshake. For any other kind it is the external transfer-acknowledge input, guarded by a bus-timeout counter. An access that breaks the region's protection is refused with a one-clock error pulse, and chip select is never asserted for it. A read from a region with address hold enabled keeps the address and attribute strobe valid for one clock after chip select drops.

Requests use a valid/ready handshake. The block takes a new request only when it is idle, which means the previous access has fully ended, including its hold clock.

Top module: `cs_term_ctrl`

## Requirements
- R1: A request is accepted on a clock edge where req_valid and req_ready are both high. For wait code N in 0..30, cs_sel asserts in cycle 1 after acceptance and ack pulses in cycle N+1. Code 0 therefore acknowledges in the first select cycle.
- R2: After reset, region 0 holds wait code 30 and every other region holds wait code 0, with all other option fields 0.
- R3: With wait code 31 and a memory kind other than 01, no internal acknowledge is produced. ack pulses in the first cycle where ext_ta is high.
- R4: With wait code 31 and a memory kind other than 01, bus_err pulses in cycle TIMEOUT_CYC after acceptance if ext_ta has not been seen by then. An ext_ta in that same cycle ends the access with ack and no bus_err.
- R5: With wait code 31 and memory kind 01, sdram_start pulses in cycle 1. ack pulses in the first cycle from cycle 2 on where sdram_done is high. ext_ta has no effect on such an access.
- R6: When the protect enable is 0, the region accepts both reads and writes. When it is 1, a direction bit of 0 makes the region read-only and a direction bit of 1 makes it write-only.
- R7: An access that violates protection gives a single prot_err pulse in cycle 1. It gives no ack and no bus_err, and cs_sel stays 0 throughout.
- R8: After a read that ends by ack or bus_err in a region with address hold set, the next cycle has addr_valid high, cs_sel at 0 and req_ready low. Writes, and reads from regions with hold clear, return to ready in the cycle after termination.
- R9: req_ready is high only when no access is in progress. cs_sel is either zero or the one-hot bit of the accepted region.
- R10: ack, prot_err, bus_err and sdram_start are single-cycle pulses, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write the option set of region cfg_idx |
| cfg_idx | input | 3 | Region selected for the option write |
| cfg_wait | input | 5 | Wait code: 0..30 internal, 31 outside termination |
| cfg_rd_hold | input | 1 | Hold address/attributes one clock after reads |
| cfg_prot_en | input | 1 | Enable read/write protection |
| cfg_wr_only | input | 1 | Protection direction: 0 read-only, 1 write-only |
| cfg_mem_kind | input | 2 | Memory kind; 01 selects SDRAM handoff |
| req_valid | input | 1 | Decoded access request |
| req_idx | input | 3 | Region hit by the request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_ready | output | 1 | Block idle, request can be taken |
| ext_ta | input | 1 | External transfer acknowledge |
| sdram_done | input | 1 | SDRAM controller finished the access |
| cs_sel | output | 8 | One-hot chip select |
| addr_valid | output | 1 | Address and attributes valid |
| ack | output | 1 | Access terminated normally |
| prot_err | output | 1 | Protection violation |
| bus_err | output | 1 | Outside termination timed out |
| sdram_start | output | 1 | Handoff pulse to the SDRAM controller |

## Verification
The bench measures the acknowledge cycle at both ends of the internal range (code 0 and code 30) and at a mid value. An off-by-one counter would show up there as an acknowledge one clock early or late. It drives ext_ta exactly in the timeout cycle and into an SDRAM-kind access. A design with the wrong priority would raise a bus error, and one that lets ext_ta through would end the SDRAM access early. Protection is tested in both directions and with protection disabled, so an inverted direction bit would refuse the legal access. The hold clock is checked for reads and writes, with hold set and clear: a design that holds after writes, or that accepts a new request during the hold clock, shows a wrong addr_valid or req_ready level.

// File: rtl/cs_term_pkg.sv
package cs_term_pkg;
    localparam int WAIT_W   = 5;
    localparam int WAIT_EXT = 31;
    localparam logic [1:0] KIND_SDRAM = 2'b01;

    typedef struct packed {
        logic [WAIT_W-1:0] wait_code;
        logic              rd_hold;
        logic              prot_en;
        logic              wr_only;
        logic [1:0]        mem_kind;
    } region_opt_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_EXT,
        ST_SDR_GO,
        ST_SDR,
        ST_HOLD,
        ST_ERR
    } term_st_e;
endpackage

// File: rtl/cs_opt_regs.sv
module cs_opt_regs
    import cs_term_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int IDX_W = $clog2(NUM_REGIONS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  region_opt_t       wr_opt,
    input  logic [IDX_W-1:0]  rd_idx,
    output region_opt_t       rd_opt
);
    region_opt_t opt_q [NUM_REGIONS];

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        localparam logic [WAIT_W-1:0] RST_WAIT = (g == 0) ? WAIT_W'(30) : '0;
        region_opt_t opt_d;

        always_comb begin
            opt_d = opt_q[g];
            if (wr_en && wr_idx == IDX_W'(g)) begin
                opt_d = wr_opt;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                opt_q[g] <= '{wait_code: RST_WAIT, rd_hold: 1'b0, prot_en: 1'b0,
                              wr_only: 1'b0, mem_kind: 2'b00};
            end else begin
                opt_q[g] <= opt_d;
            end
        end
    end

    assign rd_opt = opt_q[rd_idx];
endmodule

// File: rtl/cs_prot_chk.sv
module cs_prot_chk (
    input  logic prot_en,
    input  logic wr_only,
    input  logic is_write,
    output logic viol
);
    // R6: read-only regions refuse writes, write-only regions refuse reads
    always_comb begin
        viol = prot_en && (wr_only != is_write);
    end
endmodule

// File: rtl/cs_term_fsm.sv
module cs_term_fsm
    import cs_term_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int TIMEOUT_CYC = 256,
    parameter int IDX_W = $clog2(NUM_REGIONS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [IDX_W-1:0]       start_idx,
    input  logic                   start_wr,
    input  logic [WAIT_W-1:0]      wait_code,
    input  logic                   rd_hold,
    input  logic [1:0]             mem_kind,
    input  logic                   viol,
    input  logic                   ext_ta,
    input  logic                   sdram_done,
    output logic                   ready,
    output logic                   ack,
    output logic                   err,
    output logic                   berr,
    output logic                   sdr_go,
    output logic [NUM_REGIONS-1:0] cs_sel,
    output logic                   addr_valid
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT_CYC - 1);

    typedef struct packed {
        term_st_e          st;
        logic [WAIT_W-1:0] cnt;
        logic [TW-1:0]     tcnt;
        logic              is_rd;
        logic              hold;
        logic [IDX_W-1:0]  idx;
    } fsm_t;

    fsm_t s_d, s_q;
    logic term;
    logic cs_on;

    always_comb begin
        s_d    = s_q;
        ack    = 1'b0;
        err    = 1'b0;
        berr   = 1'b0;
        sdr_go = 1'b0;
        term   = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.idx   = start_idx;
                    s_d.is_rd = !start_wr;
                    s_d.hold  = rd_hold;
                    s_d.cnt   = wait_code;
                    s_d.tcnt  = '0;
                    if (viol) begin
                        s_d.st = ST_ERR;
                    end else if (wait_code == WAIT_W'(WAIT_EXT)) begin
                        s_d.st = (mem_kind == KIND_SDRAM) ? ST_SDR_GO : ST_EXT;
                    end else begin
                        s_d.st = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (s_q.cnt == '0) begin
                    ack  = 1'b1;
                    term = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_EXT: begin
                if (ext_ta) begin
                    ack  = 1'b1;
                    term = 1'b1;
                end else if (s_q.tcnt == T_LAST) begin
                    berr = 1'b1;
                    term = 1'b1;
                end else begin
                    s_d.tcnt = s_q.tcnt + 1'b1;
                end
            end
            ST_SDR_GO: begin
                sdr_go = 1'b1;
                s_d.st = ST_SDR;
            end
            ST_SDR: begin
                if (sdram_done) begin
                    ack  = 1'b1;
                    term = 1'b1;
                end
            end
            ST_HOLD: s_d.st = ST_IDLE;
            ST_ERR: begin
                err    = 1'b1;
                s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
        if (term) begin
            s_d.st = (s_q.is_rd && s_q.hold) ? ST_HOLD : ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, cnt: '0, tcnt: '0, is_rd: 1'b0, hold: 1'b0, idx: '0};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        cs_on = (s_q.st == ST_WAIT) || (s_q.st == ST_EXT) ||
                (s_q.st == ST_SDR_GO) || (s_q.st == ST_SDR);
        cs_sel     = cs_on ? (NUM_REGIONS'(1) << s_q.idx) : '0;
        addr_valid = cs_on || (s_q.st == ST_HOLD);
        ready      = (s_q.st == ST_IDLE);
    end

    // R10
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ack, err, berr, sdr_go}) <= 1);

    // R10
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R7
    err_no_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (cs_sel == '0));

    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ack || berr) && s_q.is_rd && s_q.hold) |=> (addr_valid && cs_sel == '0 && !ready));

    // R5
    sdr_ignore_ta_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_SDR && !sdram_done) |-> !ack);

    // R9
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_sel));

    // R9
    busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !ready);
endmodule

// File: rtl/cs_term_ctrl.sv
module cs_term_ctrl
    import cs_term_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int TIMEOUT_CYC = 256,
    parameter int IDX_W = $clog2(NUM_REGIONS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [IDX_W-1:0]       cfg_idx,
    input  logic [WAIT_W-1:0]      cfg_wait,
    input  logic                   cfg_rd_hold,
    input  logic                   cfg_prot_en,
    input  logic                   cfg_wr_only,
    input  logic [1:0]             cfg_mem_kind,
    input  logic                   req_valid,
    input  logic [IDX_W-1:0]       req_idx,
    input  logic                   req_write,
    output logic                   req_ready,
    input  logic                   ext_ta,
    input  logic                   sdram_done,
    output logic [NUM_REGIONS-1:0] cs_sel,
    output logic                   addr_valid,
    output logic                   ack,
    output logic                   prot_err,
    output logic                   bus_err,
    output logic                   sdram_start
);
    region_opt_t wr_opt, cur_opt;
    logic        viol;
    logic        start;

    assign wr_opt = '{wait_code: cfg_wait, rd_hold: cfg_rd_hold, prot_en: cfg_prot_en,
                      wr_only: cfg_wr_only, mem_kind: cfg_mem_kind};
    assign start  = req_valid && req_ready;

    cs_opt_regs #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)) u_opts (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .wr_idx (cfg_idx),
        .wr_opt (wr_opt),
        .rd_idx (req_idx),
        .rd_opt (cur_opt)
    );

    cs_prot_chk u_prot (
        .prot_en  (cur_opt.prot_en),
        .wr_only  (cur_opt.wr_only),
        .is_write (req_write),
        .viol     (viol)
    );

    cs_term_fsm #(.NUM_REGIONS(NUM_REGIONS), .TIMEOUT_CYC(TIMEOUT_CYC), .IDX_W(IDX_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_idx  (req_idx),
        .start_wr   (req_write),
        .wait_code  (cur_opt.wait_code),
        .rd_hold    (cur_opt.rd_hold),
        .mem_kind   (cur_opt.mem_kind),
        .viol       (viol),
        .ext_ta     (ext_ta),
        .sdram_done (sdram_done),
        .ready      (req_ready),
        .ack        (ack),
        .err        (prot_err),
        .berr       (bus_err),
        .sdr_go     (sdram_start),
        .cs_sel     (cs_sel),
        .addr_valid (addr_valid)
    );
endmodule

// File: tb/tb_cs_term_ctrl.sv
module tb_cs_term_ctrl;
    localparam int TMO = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_idx = '0;
    logic [4:0] cfg_wait = '0;
    logic       cfg_rd_hold = 1'b0, cfg_prot_en = 1'b0, cfg_wr_only = 1'b0;
    logic [1:0] cfg_mem_kind = '0;
    logic       req_valid = 1'b0;
    logic [2:0] req_idx = '0;
    logic       req_write = 1'b0;
    logic       req_ready;
    logic       ext_ta = 1'b0, sdram_done = 1'b0;
    logic [7:0] cs_sel;
    logic       addr_valid, ack, prot_err, bus_err, sdram_start;

    int n_chk = 0, n_fail = 0;
    int r_ack, r_err, r_berr, r_start, r_end;
    bit r_cs_any, r_sel_bad, r_multi, r_hold, r_rdy1, r_rdy2;

    always #2.5 clk = ~clk;

    cs_term_ctrl #(.NUM_REGIONS(8), .TIMEOUT_CYC(TMO)) dut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cfg(input int rg, input int wt, input bit hold, input bit pen,
                       input bit wo, input int kind);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'(rg); cfg_wait = 5'(wt); cfg_rd_hold = hold;
        cfg_prot_en = pen; cfg_wr_only = wo; cfg_mem_kind = 2'(kind);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Runs one access; ta_at/done_at give the cycle (after acceptance) to pulse the input.
    task automatic do_access(input int rg, input bit wr, input int ta_at,
                             input int done_at, input int maxc);
        r_ack = 0; r_err = 0; r_berr = 0; r_start = 0; r_end = 0;
        r_cs_any = 0; r_sel_bad = 0; r_multi = 0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_idx = 3'(rg); req_write = wr;
        for (int c = 1; c <= maxc && r_end == 0; c++) begin
            @(negedge clk);
            req_valid = 1'b0;
            ext_ta = (c == ta_at);
            sdram_done = (c == done_at);
            #1;
            if (ack && r_ack == 0) r_ack = c;
            if (prot_err && r_err == 0) r_err = c;
            if (bus_err && r_berr == 0) r_berr = c;
            if (sdram_start && r_start == 0) r_start = c;
            if (cs_sel != 0) r_cs_any = 1;
            if (cs_sel != 0 && cs_sel != (8'd1 << rg)) r_sel_bad = 1;
            if ((int'(ack) + int'(prot_err) + int'(bus_err) + int'(sdram_start)) > 1) r_multi = 1;
            if (ack || prot_err || bus_err) r_end = c;
        end
        @(negedge clk);
        ext_ta = 1'b0; sdram_done = 1'b0;
        #1;
        r_hold = addr_valid && cs_sel == 0 && !req_ready;
        r_rdy1 = req_ready;
        if (!r_rdy1) begin
            @(negedge clk); #1;
            r_rdy2 = req_ready;
        end else begin
            r_rdy2 = 1'b1;
        end
    endtask

    task automatic t_reset;
        chk(req_ready == 1'b1, "R9 reset ready", int'(req_ready), 1);
        chk(cs_sel == 0 && !ack && !prot_err && !bus_err && !sdram_start && !addr_valid,
            "R10 reset outputs quiet", int'(cs_sel), 0);
    endtask

    task automatic t_defaults;
        do_access(0, 1'b0, 0, 0, 60);
        chk(r_ack == 31, "R2 region0 default code 30", r_ack, 31);
        do_access(5, 1'b1, 0, 0, 60);
        chk(r_ack == 1, "R2 region5 default code 0", r_ack, 1);
        chk(!r_sel_bad && r_cs_any, "R9 cs one-hot region", int'(r_sel_bad), 0);
    endtask

    task automatic t_wait_codes;
        cfg(2, 5, 0, 0, 0, 0);
        do_access(2, 1'b0, 0, 0, 60);
        chk(r_ack == 6, "R1 code 5 ack cycle", r_ack, 6);
        chk(r_rdy1, "R8 read without hold returns ready", int'(r_rdy1), 1);
        cfg(2, 0, 0, 0, 0, 0);
        do_access(2, 1'b0, 0, 0, 60);
        chk(r_ack == 1, "R1 code 0 ack cycle", r_ack, 1);
        cfg(3, 30, 0, 0, 0, 0);
        do_access(3, 1'b1, 0, 0, 60);
        chk(r_ack == 31, "R1 code 30 ack cycle", r_ack, 31);
        chk(!r_multi, "R10 pulses exclusive", int'(r_multi), 0);
    endtask

    task automatic t_external;
        cfg(4, 31, 0, 0, 0, 2'b00);
        do_access(4, 1'b0, 10, 0, 300);
        chk(r_ack == 10 && r_berr == 0, "R3 ext_ta ends access", r_ack, 10);
        cfg(4, 31, 0, 0, 0, 2'b11);
        do_access(4, 1'b1, 0, 0, 300);
        chk(r_berr == TMO && r_ack == 0, "R4 timeout bus error", r_berr, TMO);
        do_access(4, 1'b1, TMO, 0, 300);
        chk(r_ack == TMO && r_berr == 0, "R4 ext_ta wins in last cycle", r_ack, TMO);
    endtask

    task automatic t_sdram;
        cfg(6, 31, 0, 0, 0, 2'b01);
        do_access(6, 1'b0, 3, 5, 300);
        chk(r_start == 1, "R5 sdram_start cycle", r_start, 1);
        chk(r_ack == 5, "R5 ext_ta ignored, done ends", r_ack, 5);
        chk(r_berr == 0, "R5 no timeout on sdram", r_berr, 0);
    endtask

    task automatic t_protect;
        cfg(1, 2, 0, 1, 0, 0);
        do_access(1, 1'b1, 0, 0, 60);
        chk(r_err == 1 && r_ack == 0, "R7 write to read-only refused", r_err, 1);
        chk(!r_cs_any, "R7 no cs on violation", int'(r_cs_any), 0);
        do_access(1, 1'b0, 0, 0, 60);
        chk(r_ack == 3 && r_err == 0, "R6 read from read-only allowed", r_ack, 3);
        cfg(1, 2, 0, 1, 1, 0);
        do_access(1, 1'b0, 0, 0, 60);
        chk(r_err == 1 && r_ack == 0, "R6 read from write-only refused", r_err, 1);
        do_access(1, 1'b1, 0, 0, 60);
        chk(r_ack == 3, "R6 write to write-only allowed", r_ack, 3);
        cfg(1, 2, 0, 0, 1, 0);
        do_access(1, 1'b0, 0, 0, 60);
        chk(r_ack == 3 && r_err == 0, "R6 disabled protect allows read", r_ack, 3);
    endtask

    task automatic t_hold;
        cfg(7, 1, 1, 0, 0, 0);
        do_access(7, 1'b0, 0, 0, 60);
        chk(r_ack == 2, "R1 code 1 ack cycle", r_ack, 2);
        chk(r_hold, "R8 hold clock after read", int'(r_hold), 1);
        chk(r_rdy2, "R8 ready after hold clock", int'(r_rdy2), 1);
        do_access(7, 1'b1, 0, 0, 60);
        chk(!r_hold && r_rdy1, "R8 no hold after write", int'(r_rdy1), 1);
        cfg(7, 31, 1, 0, 0, 0);
        do_access(7, 1'b0, 0, 0, 300);
        chk(r_berr == TMO && r_hold, "R8 hold after bus error read", int'(r_hold), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset();
        t_defaults();
        t_wait_codes();
        t_external();
        t_sdram();
        t_protect();
        t_hold();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule